// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the operand-routing controller of a five-stage in-order integer pipeline. For each of the two source operands of the instruction now in the execute stage, it picks where the ALU should take the value from. The choices are the register file, the result waiting in the execute/memory latch, or the result waiting in the memory/writeback latch. When both latches hold a matching producer, the younger one (execute/memory) wins. Instructions three or more slots ahead need no bypass. The register file writes early in the cycle and reads late, so a reader three slots behind already sees the new value.

One dependence cannot be bypassed. A load's data exists only after the memory stage. An instruction right behind a load that reads the loaded register therefore cannot get its operand in time. The block watches the decode-stage instruction against a load sitting in execute. On a match it freezes fetch for one cycle (the program counter and the fetch/decode latch keep their contents) and asks for the decode/execute latch's control bits to be cleared, which turns that slot into a bubble. The next cycle the load has moved to the memory stage. The normal memory/writeback bypass then feeds the waiting instruction.

The second operand's select is produced from register fields alone, with no regard to opcode. A store's data operand therefore picks up forwarded values in the same way as an ALU operand. The block is purely combinational; the operand multiplexers and the pipeline latches are outside it.

Top module: `bypass_ctrl`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register file, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result; 2'b11 never appears.
- R2: An operand selects 2'b10 when its execute-stage source register is nonzero, equals `exmem_dst`, and `exmem_we` is high.
- R3: When R2 does not apply, an operand selects 2'b01 when its source is nonzero, equals `memwb_dst`, and `memwb_we` is high.
- R4: When both latches match a source under R2 and R3, the select is 2'b10 (youngest producer first).
- R5: A source field of zero always selects 2'b00, even if a latch writes register zero with its write enable set.
- R6: A latch whose write enable is low is never selected, whatever its destination field holds.
- R7: Operand A's select depends only on `ex_src_a` and operand B's only on `ex_src_b`; the two are decided independently, so both may forward from different latches at once.
- R8: `fetch_hold` and `idex_bubble` are both high when `idex_memread` is high, `idex_dst` is nonzero, and `idex_dst` equals a decode-stage source whose use flag is set (`id_src_a` with `id_use_a`, or `id_src_b` with `id_use_b`).
- R9: `fetch_hold` and `idex_bubble` stay low when the execute-stage instruction is not a load, when the load writes register zero, or when the only matching decode source has its use flag low.
- R10: `fetch_hold` and `idex_bubble` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute (also store data) |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| id_use_a | input | 1 | Decode instruction actually reads its first source |
| id_use_b | input | 1 | Decode instruction actually reads its second source |
| idex_dst | input | 5 | Load destination field held in the decode/execute latch |
| idex_memread | input | 1 | Instruction in execute is a load |
| exmem_dst | input | 5 | Destination register in the execute/memory latch |
| exmem_we | input | 1 | Register write enable in the execute/memory latch |
| memwb_dst | input | 5 | Destination register in the memory/writeback latch |
| memwb_we | input | 1 | Register write enable in the memory/writeback latch |
| fwd_a | output | 2 | Operand A select (R1 encoding) |
| fwd_b | output | 2 | Operand B / store-data select (R1 encoding) |
| fetch_hold | output | 1 | Hold program counter and fetch/decode latch this cycle |
| idex_bubble | output | 1 | Clear decode/execute control bits this cycle |

## Verification
The hardest cases to reach are the ones where several conditions overlap. One is a source matched by both latches, where only the priority order settles the select. The others are near-misses: a latch writing register zero with its enable set, and a load whose destination matches a decode field that the instruction does not read. The stimulus sets each of these up on purpose as a single-cycle pattern, with every other latch field set to a non-matching value. Each pattern is then paired with a control vector that differs in only the one deciding bit, so a wrong result points at that bit.

// File: rtl/bypass_pkg.sv
// Shared definitions for the bypass controller.
// Assumes a register file indexed by a small binary address, with register zero hardwired.
package bypass_pkg;
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/operand_fwd_sel.sv
// Chooses the source of one execute-stage operand.
// Assumes the register file covers distance three and beyond by writing before it reads,
// so only the two downstream latches are examined, with the younger one checked first.
module operand_fwd_sel #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exmem_dst,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_dst,
    input  logic          memwb_we,
    output logic [1:0]    sel
);
    import bypass_pkg::*;

    logic     src_live;
    logic     hit_exmem;
    logic     hit_memwb;
    fwd_sel_e choice;

    // Qualify each latch as a producer of this operand.
    always_comb begin
        src_live  = (src != '0);
        hit_exmem = src_live && exmem_we && (exmem_dst == src);
        hit_memwb = src_live && memwb_we && (memwb_dst == src);
    end

    // Priority pick: youngest producer, then older producer, else register file.
    always_comb begin
        if (hit_exmem)      choice = SEL_EXMEM;
        else if (hit_memwb) choice = SEL_MEMWB;
        else                choice = SEL_REGFILE;
    end

    assign sel = choice;
endmodule

// File: rtl/load_use_detect.sv
// Flags a decode-stage instruction that reads the register a load in execute will write.
// Assumes decode supplies a use flag per source so unused fields never cause a stall.
module load_use_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     ld_in_ex,
    input  logic [AW-1:0]            ld_dst,
    input  logic [NSRC-1:0][AW-1:0]  dec_src,
    input  logic [NSRC-1:0]          dec_use,
    output logic                     hazard
);
    logic [NSRC-1:0] src_hit;
    logic            ld_real;

    // A load into register zero produces nothing a reader depends on.
    always_comb ld_real = ld_in_ex && (ld_dst != '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Per-source comparison against the load destination.
        always_comb src_hit[g] = dec_use[g] && (dec_src[g] == ld_dst);
    end

    // Any used source matching a live load needs one bubble.
    always_comb hazard = ld_real && (|src_hit);
endmodule

// File: rtl/bypass_ctrl.sv
// Top of the operand bypass controller: one selector per execute operand plus the
// load-use interlock. Purely combinational; the operand multiplexers and pipeline
// latches are outside. The second operand select also steers store data.
module bypass_ctrl #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic [AW-1:0] idex_dst,
    input  logic          idex_memread,
    input  logic [AW-1:0] exmem_dst,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_dst,
    input  logic          memwb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          fetch_hold,
    output logic          idex_bubble
);
    localparam int NOPER = 2;

    logic [NOPER-1:0][AW-1:0] ex_src;
    logic [NOPER-1:0][1:0]    op_sel;
    logic [NOPER-1:0][AW-1:0] id_src;
    logic [NOPER-1:0]         id_use;
    logic                     stall;

    // Gather per-operand fields into arrays for the generate loop.
    always_comb begin
        ex_src = {ex_src_b, ex_src_a};
        id_src = {id_src_b, id_src_a};
        id_use = {id_use_b, id_use_a};
    end

    for (genvar op = 0; op < NOPER; op++) begin : g_oper
        operand_fwd_sel #(.AW(AW)) u_sel (
            .src       (ex_src[op]),
            .exmem_dst (exmem_dst),
            .exmem_we  (exmem_we),
            .memwb_dst (memwb_dst),
            .memwb_we  (memwb_we),
            .sel       (op_sel[op])
        );
    end

    load_use_detect #(.AW(AW), .NSRC(NOPER)) u_lu (
        .ld_in_ex (idex_memread),
        .ld_dst   (idex_dst),
        .dec_src  (id_src),
        .dec_use  (id_use),
        .hazard   (stall)
    );

    // Drive outputs: selects per operand, one stall fanned to fetch and the bubble.
    always_comb begin
        fwd_a       = op_sel[0];
        fwd_b       = op_sel[1];
        fetch_hold  = stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/bypass_ctrl_checker.sv
// Property checker for bypass_ctrl, attached by bind. Immediate checks on the
// combinational relation between latch fields and the produced controls.
module bypass_ctrl_checker #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic          idex_memread,
    input logic [AW-1:0] idex_dst,
    input logic [AW-1:0] exmem_dst,
    input logic          exmem_we,
    input logic [AW-1:0] memwb_dst,
    input logic          memwb_we,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          fetch_hold,
    input logic          idex_bubble
);
    // Check select legality, producer justification, priority and stall consistency.
    always_comb begin
        assert_sel_legal_R1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
        if (fwd_a == 2'b10)
            assert_exmem_just_R2: assert (exmem_we && ex_src_a != '0 && exmem_dst == ex_src_a);
        if (fwd_b == 2'b01)
            assert_memwb_just_R3: assert (memwb_we && ex_src_b != '0 && memwb_dst == ex_src_b);
        if (exmem_we && memwb_we && exmem_dst == memwb_dst && ex_src_a == exmem_dst && ex_src_a != '0)
            assert_young_wins_R4: assert (fwd_a == 2'b10);
        if (ex_src_b == '0)
            assert_zero_src_R5: assert (fwd_b == 2'b00);
        if (fetch_hold)
            assert_stall_needs_load_R9: assert (idex_memread && idex_dst != '0);
        assert_hold_eq_bubble_R10: assert (fetch_hold == idex_bubble);
    end
endmodule

bind bypass_ctrl bypass_ctrl_checker #(.AW(AW)) u_bypass_ctrl_chk (
    .ex_src_a     (ex_src_a),
    .ex_src_b     (ex_src_b),
    .idex_memread (idex_memread),
    .idex_dst     (idex_dst),
    .exmem_dst    (exmem_dst),
    .exmem_we     (exmem_we),
    .memwb_dst    (memwb_dst),
    .memwb_we     (memwb_we),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .fetch_hold   (fetch_hold),
    .idex_bubble  (idex_bubble)
);

// File: tb/bypass_ctrl_bench.sv
// Scoreboard bench: the driver applies a vector at a rising edge and queues the
// expected controls; the monitor pops and compares at the following falling edge.
module bypass_ctrl_bench;
    localparam int AW = 5;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       st;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, id_src_a = '0, id_src_b = '0;
    logic          id_use_a = 1'b0, id_use_b = 1'b0;
    logic [AW-1:0] idex_dst = '0, exmem_dst = '0, memwb_dst = '0;
    logic          idex_memread = 1'b0, exmem_we = 1'b0, memwb_we = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          fetch_hold, idex_bubble;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    bypass_ctrl #(.AW(AW)) u_bypass_ctrl (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_use_a(id_use_a), .id_use_b(id_use_b),
        .idex_dst(idex_dst), .idex_memread(idex_memread),
        .exmem_dst(exmem_dst), .exmem_we(exmem_we),
        .memwb_dst(memwb_dst), .memwb_we(memwb_we),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .fetch_hold(fetch_hold), .idex_bubble(idex_bubble)
    );

    // Expected select from the requirement text: younger latch first, zero never forwards.
    function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
        if (s == 0) return 2'b00;
        if (exmem_we && exmem_dst == s) return 2'b10;
        if (memwb_we && memwb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    // Apply one vector of latch fields and queue what R1..R10 predict.
    task automatic drive(string tag,
                         logic [AW-1:0] xa, logic [AW-1:0] xb,
                         logic [AW-1:0] em_d, logic em_w,
                         logic [AW-1:0] mw_d, logic mw_w,
                         logic ld, logic [AW-1:0] ld_d,
                         logic [AW-1:0] da, logic ua,
                         logic [AW-1:0] db, logic ub);
        exp_t e;
        @(posedge clk);
        ex_src_a = xa; ex_src_b = xb;
        exmem_dst = em_d; exmem_we = em_w;
        memwb_dst = mw_d; memwb_we = mw_w;
        idex_memread = ld; idex_dst = ld_d;
        id_src_a = da; id_use_a = ua;
        id_src_b = db; id_use_b = ub;
        e.a   = ref_sel(xa);
        e.b   = ref_sel(xb);
        e.st  = ld && (ld_d != 0) && ((ua && da == ld_d) || (ub && db == ld_d));
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each queued expectation half a cycle after its vector.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (fwd_a !== e.a || fwd_b !== e.b || fetch_hold !== e.st || idex_bubble !== e.st) begin
                    errors++;
                    $display("FAIL %s: got a=%b b=%b hold=%b bub=%b, expected a=%b b=%b hold=%b bub=%b",
                             e.tag, fwd_a, fwd_b, fetch_hold, idex_bubble, e.a, e.b, e.st, e.st);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Quiescent state, all fields zero: register file, no stall (R1, R5).
        drive("R1_idle",       0, 0,  0,0,  0,0,  0,0,  0,0, 0,0);
        // R2: execute/memory producer for A; B unrelated.
        drive("R2_exmem_a",    3, 4,  3,1,  9,1,  0,0,  0,0, 0,0);
        // R2 on operand B: store data picks up the forward.
        drive("R2_exmem_b",    7, 12, 12,1, 9,1,  0,0,  0,0, 0,0);
        // R3: only memory/writeback matches.
        drive("R3_memwb",      6, 6,  2,1,  6,1,  0,0,  0,0, 0,0);
        // R4: both latches hold the same destination.
        drive("R4_priority",   8, 8,  8,1,  8,1,  0,0,  0,0, 0,0);
        // R5: register zero with write enables set.
        drive("R5_zero_src",   0, 0,  0,1,  0,1,  0,0,  0,0, 0,0);
        // R6: matching destination but write enable low on the younger latch.
        drive("R6_we_low_em",  5, 5,  5,0,  5,1,  0,0,  0,0, 0,0);
        // R6: both enables low.
        drive("R6_we_low_all", 5, 5,  5,0,  5,0,  0,0,  0,0, 0,0);
        // R7: A from execute/memory, B from memory/writeback simultaneously.
        drive("R7_split",      10, 11, 10,1, 11,1, 0,0, 0,0, 0,0);
        // R7: swapped roles.
        drive("R7_swap",       11, 10, 10,1, 11,1, 0,0, 0,0, 0,0);
        // R8: load destination read by decode source A.
        drive("R8_lu_a",       0, 0,  0,0,  0,0,  1,14, 14,1, 2,1);
        // R8: load destination read by decode source B.
        drive("R8_lu_b",       0, 0,  0,0,  0,0,  1,14, 2,1, 14,1);
        // R9: same fields but not a load.
        drive("R9_not_load",   0, 0,  0,0,  0,0,  0,14, 14,1, 14,1);
        // R9: load into register zero.
        drive("R9_ld_r0",      0, 0,  0,0,  0,0,  1,0,  0,1, 0,1);
        // R9: matching source not actually used.
        drive("R9_unused",     0, 0,  0,0,  0,0,  1,14, 14,0, 3,1);
        // R10 with forwarding active during a stall.
        drive("R10_combo",     14, 9, 14,1, 9,1, 1,20, 1,0, 20,1);
        // Sweep: every source against a fixed pair of producers (R2, R3, R4).
        for (int s = 0; s < 32; s++) begin
            drive("R4_sweep", s[AW-1:0], 5'(31 - s), 5'd17,1, 5'd17,1, 1'b1, s[AW-1:0], 5'd17,1, 5'd0,0);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule